// File: doc/BRIEF.md
# Parallel CRC Remainder Table Generator

This block fills the per-bit weight table that a wide, single-cycle CRC datapath needs. For a generator of degree m and a data block of W bits, the datapath XORs together one m-bit constant for every set bit of the block. The constant for bit position j is the remainder of x^j divided by the generator. This generator builds those W constants at run time instead of holding them in a ROM.

After a start pulse, the engine writes one constant per clock through a simple write port (enable, address, data). That port can load a register file or a small RAM. The sweep starts from x^0, which is a single 1. Each following entry comes from the previous one: multiply by x, then fold the bit that leaves the m-bit field back in through the generator taps. A one-cycle completion pulse follows the final write. The generator taps, the degree m and the block width W are all parameters.

Top module: `crc_tbl_gen`

## Requirements
- R1: While reset is held, and after it is released with no start, `busy`, `done` and `tbl_we` are all 0.
- R2: A `start` pulse taken while idle makes `busy` and `tbl_we` rise on the next clock. They stay high for exactly TBL_W consecutive cycles.
- R3: `tbl_addr` takes the values 0, 1, …, TBL_W-1 on consecutive write cycles, one entry per clock in ascending order.
- R4: The entry at address 0 is the value 1, which is the remainder of x^0.
- R5: The entry at address j equals x^j mod G, where G is x^GEN_DEG plus the GEN_TAPS bit pattern (bit i of GEN_TAPS is the coefficient of x^i). Each entry is the previous one shifted up one place, XORed with GEN_TAPS whenever the bit leaving position GEN_DEG-1 was 1.
- R6: `done` is high for exactly one cycle, the cycle right after the last write. During that cycle `busy` and `tbl_we` are 0.
- R7: A `start` that arrives while `busy` is high has no effect. The ongoing sweep keeps its addresses, its data and its end time, and no second sweep follows.
- R8: A `start` taken in the `done` cycle, or any time later, begins a new sweep on the next clock. The new sweep produces the same table again.
- R9: For every address j below GEN_DEG, the entry has only bit j set.
- R10: The same behaviour holds for other parameter sets. This includes a 16-bit generator (taps 0x1021) with a block width of 24, which is not a power of two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Request to build the table; only acted on when not busy |
| busy | output | 1 | High while table entries are being written |
| done | output | 1 | One-cycle pulse after the last entry is written |
| tbl_we | output | 1 | Write enable for the table storage |
| tbl_addr | output | ADDR_W | Entry index, bit position in the data block |
| tbl_data | output | GEN_DEG | Remainder of x^tbl_addr modulo the generator |

## Verification
The assertions assume that `start` is a clean synchronous level with no X after reset. They also assume that reset is asserted from time zero, so every state register holds a defined value before any property is sampled. The bench respects both assumptions: it holds `rst_n` low from the first instant and changes `start` only on falling clock edges. It also lets the internal reset synchronizer settle for several cycles before the first request. Requests placed mid-sweep and in the done cycle exercise the ignore and restart paths under these same conditions.

// File: rtl/crc_tbl_pkg.sv
package crc_tbl_pkg;

  // Sweep controller states
  typedef enum logic [1:0] {
    SW_IDLE = 2'd0,
    SW_RUN  = 2'd1,
    SW_FIN  = 2'd2
  } sweep_state_e;

endpackage

// File: rtl/crc_tbl_rst_sync.sv
module crc_tbl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/crc_tbl_step.sv
// One multiply-by-x step modulo the generator, purely combinational.
module crc_tbl_step #(
  parameter int              GEN_DEG  = 32,
  parameter logic [GEN_DEG-1:0] GEN_TAPS = 32'h04C11DB7
) (
  input  logic [GEN_DEG-1:0] cur_rem,
  output logic [GEN_DEG-1:0] nxt_rem
);

  logic fold;
  assign fold = cur_rem[GEN_DEG-1];

  for (genvar i = 0; i < GEN_DEG; i++) begin : g_bit
    if (i == 0) begin : g_lsb
      assign nxt_rem[i] = fold & GEN_TAPS[i];
    end else begin : g_upper
      assign nxt_rem[i] = cur_rem[i-1] ^ (fold & GEN_TAPS[i]);
    end
  end

endmodule

// File: rtl/crc_tbl_rem_reg.sv
// Holds the running remainder; seeded with x^0 on a new sweep.
module crc_tbl_rem_reg #(
  parameter int GEN_DEG = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               seed_en,
  input  logic               adv_en,
  input  logic [GEN_DEG-1:0] nxt_rem,
  output logic [GEN_DEG-1:0] cur_rem
);

  localparam logic [GEN_DEG-1:0] UNIT = GEN_DEG'(1);

  logic [GEN_DEG-1:0] rem_d;
  logic               rem_ce;

  always_comb begin
    rem_ce = seed_en | adv_en;
    rem_d  = cur_rem;
    if (seed_en) begin
      rem_d = UNIT;
    end else if (adv_en) begin
      rem_d = nxt_rem;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_rem <= '0;
    end else if (rem_ce) begin
      cur_rem <= rem_d;
    end
  end

endmodule

// File: rtl/crc_tbl_ctrl.sv
module crc_tbl_ctrl
  import crc_tbl_pkg::*;
#(
  parameter int TBL_W  = 64,
  parameter int ADDR_W = (TBL_W > 1) ? $clog2(TBL_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              seed_en,
  output logic              adv_en,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] idx
);

  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(TBL_W - 1);

  sweep_state_e      st_q, st_d;
  logic [ADDR_W-1:0] idx_d;
  logic              idx_ce;
  logic              at_last;

  assign at_last = (idx == LAST_IDX);

  always_comb begin
    st_d    = st_q;
    idx_d   = idx;
    idx_ce  = 1'b0;
    seed_en = 1'b0;
    adv_en  = 1'b0;
    unique case (st_q)
      SW_IDLE, SW_FIN: begin
        st_d = SW_IDLE;
        if (start) begin
          st_d    = SW_RUN;
          seed_en = 1'b1;
          idx_d   = '0;
          idx_ce  = 1'b1;
        end
      end
      SW_RUN: begin
        adv_en = 1'b1;
        if (at_last) begin
          st_d = SW_FIN;
        end else begin
          idx_d  = idx + ADDR_W'(1);
          idx_ce = 1'b1;
        end
      end
      default: st_d = SW_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SW_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
    end else if (idx_ce) begin
      idx <= idx_d;
    end
  end

  assign busy = (st_q == SW_RUN);
  assign done = (st_q == SW_FIN);

  // R3
  addr_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !at_last) |=> (busy && idx == $past(idx) + ADDR_W'(1)));

  // R6
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && at_last) |=> (done && !busy));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  start_busy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !at_last) |=> (busy && idx != '0));

  // R2
  start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && idx == '0));

endmodule

// File: rtl/crc_tbl_gen.sv
module crc_tbl_gen #(
  parameter int                 GEN_DEG  = 32,
  parameter logic [GEN_DEG-1:0] GEN_TAPS = 32'h04C11DB7,
  parameter int                 TBL_W    = 64,
  parameter int                 ADDR_W   = (TBL_W > 1) ? $clog2(TBL_W) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  output logic               busy,
  output logic               done,
  output logic               tbl_we,
  output logic [ADDR_W-1:0]  tbl_addr,
  output logic [GEN_DEG-1:0] tbl_data
);

  logic               rst_sync_n;
  logic               seed_en;
  logic               adv_en;
  logic [GEN_DEG-1:0] cur_rem;
  logic [GEN_DEG-1:0] nxt_rem;

  crc_tbl_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  crc_tbl_ctrl #(
    .TBL_W  (TBL_W),
    .ADDR_W (ADDR_W)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start   (start),
    .seed_en (seed_en),
    .adv_en  (adv_en),
    .busy    (busy),
    .done    (done),
    .idx     (tbl_addr)
  );

  crc_tbl_rem_reg #(
    .GEN_DEG (GEN_DEG)
  ) u_rem (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .seed_en (seed_en),
    .adv_en  (adv_en),
    .nxt_rem (nxt_rem),
    .cur_rem (cur_rem)
  );

  crc_tbl_step #(
    .GEN_DEG  (GEN_DEG),
    .GEN_TAPS (GEN_TAPS)
  ) u_step (
    .cur_rem (cur_rem),
    .nxt_rem (nxt_rem)
  );

  assign tbl_we   = busy;
  assign tbl_data = cur_rem;

  // R4
  first_entry_unit_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tbl_we && tbl_addr == '0) |-> (tbl_data == GEN_DEG'(1)));

  // R1
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !busy |-> !tbl_we);

  // R6
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |-> (!busy && !tbl_we));

endmodule

// File: tb/sim_crc_tbl_gen.sv
`timescale 1ns/1ps
module sim_crc_tbl_gen;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  int checks = 0;
  int errors = 0;

  // Instance under test: 32-bit generator, 64-bit block
  logic        start_a = 1'b0;
  logic        busy_a, done_a, we_a;
  logic [5:0]  addr_a;
  logic [31:0] data_a;

  crc_tbl_gen #(.GEN_DEG(32), .GEN_TAPS(32'h04C11DB7), .TBL_W(64)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start_a), .busy(busy_a), .done(done_a),
    .tbl_we(we_a), .tbl_addr(addr_a), .tbl_data(data_a));

  // Second set: 16-bit generator, 24-bit block (R10)
  logic        start_b = 1'b0;
  logic        busy_b, done_b, we_b;
  logic [4:0]  addr_b;
  logic [15:0] data_b;

  crc_tbl_gen #(.GEN_DEG(16), .GEN_TAPS(16'h1021), .TBL_W(24)) u1 (
    .clk(clk), .rst_n(rst_n), .start(start_b), .busy(busy_b), .done(done_b),
    .tbl_we(we_b), .tbl_addr(addr_b), .tbl_data(data_b));

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Long division of x^j by the full generator, bit by bit
  function automatic logic [31:0] ref_rem(input int j, input int m, input logic [31:0] taps);
    logic [127:0] v;
    logic [127:0] g;
    v = 128'(1) << j;
    g = (128'(1) << m) | 128'(taps);
    for (int i = j; i >= m; i--) begin
      if (v[i]) v = v ^ (g << (i - m));
    end
    return v[31:0] & ((m == 32) ? 32'hFFFF_FFFF : ((32'(1) << m) - 32'(1)));
  endfunction

  task automatic set_start(input int sel, input logic v);
    if (sel == 0) start_a = v; else start_b = v;
  endtask

  task automatic grab(input int sel, output logic b, output logic d, output logic w,
                      output logic [31:0] ad, output logic [31:0] dt);
    if (sel == 0) begin
      b = busy_a; d = done_a; w = we_a; ad = 32'(addr_a); dt = data_a;
    end else begin
      b = busy_b; d = done_b; w = we_b; ad = 32'(addr_b); dt = 32'(data_b);
    end
  endtask

  // One sweep (or two back to back); poke >= 0 places a start mid-sweep
  task automatic run_table(input int sel, input int poke, input bit chain);
    int w, m;
    logic [31:0] taps;
    logic b, d, we;
    logic [31:0] ad, dt, ex;
    w    = (sel == 0) ? 64 : 24;
    m    = (sel == 0) ? 32 : 16;
    taps = (sel == 0) ? 32'h04C11DB7 : 32'h0000_1021;
    @(negedge clk); set_start(sel, 1'b1);
    @(negedge clk); set_start(sel, 1'b0);
    for (int pass = 0; pass < (chain ? 2 : 1); pass++) begin
      for (int j = 0; j < w; j++) begin
        grab(sel, b, d, we, ad, dt);
        chk(b && we && !d, (pass == 1) ? "R8 restart busy" : "R2 busy/write", {29'd0, b, we, d}, 32'd6);
        chk(ad == 32'(j), (poke >= 0) ? "R7 addr after ignored start" : "R3 address order", ad, 32'(j));
        ex = ref_rem(j, m, taps);
        if (j == 0)
          chk(dt == ex, "R4 entry zero", dt, ex);
        else
          chk(dt == ex, (sel == 1) ? "R10 entry value" : "R5 entry value", dt, ex);
        if (j < m) chk(dt == (32'(1) << j), "R9 low power", dt, 32'(1) << j);
        if (pass == 0 && j == poke) set_start(sel, 1'b1);
        @(negedge clk);
        set_start(sel, 1'b0);
      end
      grab(sel, b, d, we, ad, dt);
      chk(d && !b && !we, "R6 done pulse", {29'd0, b, we, d}, 32'd1);
      if (chain && pass == 0) begin
        set_start(sel, 1'b1);
        @(negedge clk);
        set_start(sel, 1'b0);
      end else begin
        @(negedge clk);
        grab(sel, b, d, we, ad, dt);
        chk(!d && !b && !we, (poke >= 0) ? "R7 no second sweep" : "R6 done one cycle",
            {29'd0, b, we, d}, 32'd0);
      end
    end
  endtask

  task automatic test_reset;
    logic b, d, we;
    logic [31:0] ad, dt;
    grab(0, b, d, we, ad, dt);
    chk(!b && !d && !we, "R1 in reset", {29'd0, b, we, d}, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    grab(0, b, d, we, ad, dt);
    chk(!b && !d && !we, "R1 after release", {29'd0, b, we, d}, 32'd0);
    grab(1, b, d, we, ad, dt);
    chk(!b && !d && !we, "R1 after release b", {29'd0, b, we, d}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1;
    test_reset();
    run_table(0, -1, 1'b0);   // R2 R3 R4 R5 R6 R9
    run_table(0, 5, 1'b0);    // R7
    run_table(0, -1, 1'b1);   // R8
    run_table(1, -1, 1'b0);   // R10
    run_table(1, 23, 1'b1);   // R7 at last entry, R8 on the 24-wide set
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule